// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers twelve event lines from an I2C controller into a raw interrupt status vector. A software-written mask selects which of those bits reach the single interrupt line. Most sources are sticky: a one-cycle event pulse sets the bit, and it stays set until software clears it. Two sources simply mirror the level on their input: the receive-threshold source and the transmit-threshold source.

Clearing is done with register reads, not with writes. Each source has its own clear address, and reading it returns the bit's value and then clears it. Reading a separate address clears every sticky source at once. Next to the status vector, a thirteen-bit abort-cause register collects the reason for a transfer abort. Whatever clears the abort status bit also empties this register. The register port is a single-cycle request interface with combinational read data. The clear takes effect at the clock edge that ends the read cycle.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, every sticky status bit, the mask register, the abort-cause register and `irq_o` are 0.
- R2: Status bit positions are:
  - receive underflow 0, receive overflow 1, receive threshold 2, transmit overflow 3, transmit threshold 4
  - read request 5, transfer abort 6, receive done 7, bus activity 8, stop seen 9, start seen 10, general call 11
  
  A high on `evt_i[k]` for a sticky source sets raw bit k at the next edge. The bit then holds until cleared. Raw status reads at word address 0.
- R3: Masked status, read at address 1, equals raw AND mask. `irq_o` is high exactly when any masked bit is set.
- R4: A read of address 8+k returns raw bit k in data bit 0 and clears only sticky bit k.
- R5: A read of address 4 returns 0. It clears all sticky bits and the abort-cause register.
- R6: Bits 2 and 4 follow `evt_i[2]` and `evt_i[4]` directly. Clear reads do not affect them.
- R7: If an event arrives in the same cycle as a read that clears that source, the bit stays set. For the abort register, the new cause is kept.
- R8: On each event at bit 6, `abrt_cause_i` is ORed into the abort-cause register (read at address 3). Only these cause bits are defined: 0 to 5, 7, and 9 to 12; all others stay 0. Cause input without an abort event is ignored. A read of address 14 clears the register.
- R9: The mask is written and read at address 2. Writes to addresses 0, 1 and 3 leave the state unchanged.
- R10: Writes to the clear addresses 4 and 8 to 19 clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | Event pulses (sticky sources) and levels (bits 2, 4) |
| abrt_cause_i | input | 13 | Abort reason bits, sampled with evt_i[6] |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 6 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
A fresh event can land in the same cycle as the clear read that targets its source. This applies both to a per-source clear and to the combined clear, and for the abort source to both the status bit and the cause register. The bench provokes this by raising the event and the clear read together between two edges. It then reads the raw status and the abort register. The event must have survived. For the abort register, only the new cause must remain.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_SRC  = 12;
  localparam int ABRT_W   = 13;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int SRC_ABRT = 6;

  localparam logic [NUM_SRC-1:0] LEVEL_SRC  = 12'h014;
  localparam logic [ABRT_W-1:0]  ABRT_VALID = 13'h1EBF;

  localparam int A_RAW      = 0;
  localparam int A_STAT     = 1;
  localparam int A_MASK     = 2;
  localparam int A_ABRT     = 3;
  localparam int A_CLR_ALL  = 4;
  localparam int A_CLR_BASE = 8;
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int AW   = ADDR_W
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NSRC-1:0] clr_o,
  output logic            mask_we_o
);
  logic rd, clr_all;

  assign rd        = req_i & ~we_i;
  assign clr_all   = rd && (addr_i == AW'(A_CLR_ALL));
  assign mask_we_o = req_i && we_i && (addr_i == AW'(A_MASK));

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr_o[k] = clr_all | (rd && (addr_i == AW'(A_CLR_BASE + k)));
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int               NSRC  = NUM_SRC,
  parameter logic [NSRC-1:0]  LEVEL = LEVEL_SRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    if (LEVEL[k]) begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i[k];
      assign raw_o[k]   = evt_i[k];
    end else begin : g_sticky
      logic q;
      // event has priority over a clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q & ~clr_i[k]) | evt_i[k];
      end
      assign raw_o[k] = q;
    end
  end
endmodule

// File: rtl/i2c_irq_abort.sv
module i2c_irq_abort
  import i2c_irq_pkg::*;
#(
  parameter int              AW_C  = ABRT_W,
  parameter logic [AW_C-1:0] VALID = ABRT_VALID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic            clr_i,
  input  logic [AW_C-1:0] cause_i,
  output logic [AW_C-1:0] q_o
);
  logic [AW_C-1:0] base, nxt;

  always_comb begin
    base = clr_i ? '0 : q_o;
    nxt  = evt_i ? (base | (cause_i & VALID)) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int               NSRC  = NUM_SRC,
  parameter int               AW_C  = ABRT_W,
  parameter int               DW    = DATA_W,
  parameter int               AW    = ADDR_W,
  parameter int               ABIT  = SRC_ABRT,
  parameter logic [NSRC-1:0]  LEVEL = LEVEL_SRC,
  parameter logic [AW_C-1:0]  VALID = ABRT_VALID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [AW_C-1:0] abrt_cause_i,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o
);
  logic [NSRC-1:0] clr_vec, raw, mask_q, stat;
  logic [AW_C-1:0] abrt_q;
  logic            mask_we;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DW-1:NSRC];

  i2c_irq_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .clr_o    (clr_vec),
    .mask_we_o(mask_we)
  );

  i2c_irq_status #(.NSRC(NSRC), .LEVEL(LEVEL)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .clr_i (clr_vec),
    .raw_o (raw)
  );

  i2c_irq_abort #(.AW_C(AW_C), .VALID(VALID)) u_abrt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i[ABIT]),
    .clr_i  (clr_vec[ABIT]),
    .cause_i(abrt_cause_i),
    .q_o    (abrt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata_i[NSRC-1:0];
  end

  assign stat  = raw & mask_q;
  assign irq_o = |stat;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i) begin
      if (reg_addr_i == AW'(A_RAW))       reg_rdata_o[NSRC-1:0] = raw;
      else if (reg_addr_i == AW'(A_STAT)) reg_rdata_o[NSRC-1:0] = stat;
      else if (reg_addr_i == AW'(A_MASK)) reg_rdata_o[NSRC-1:0] = mask_q;
      else if (reg_addr_i == AW'(A_ABRT)) reg_rdata_o[AW_C-1:0] = abrt_q;
      else begin
        for (int k = 0; k < NSRC; k++)
          if (reg_addr_i == AW'(A_CLR_BASE + k)) reg_rdata_o[0] = raw[k];
      end
    end
  end
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk #(
  parameter int              NSRC  = 12,
  parameter int              AW_C  = 13,
  parameter int              ABIT  = 6,
  parameter logic [NSRC-1:0] LEVEL = 12'h014
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic [NSRC-1:0] clr_i,
  input logic [NSRC-1:0] raw_i,
  input logic [NSRC-1:0] mask_i,
  input logic [AW_C-1:0] abrt_i,
  input logic            irq_i
);
  p_irq_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == |(raw_i & mask_i));

  p_sticky_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(raw_i) & ~$past(clr_i) & ~LEVEL) & ~raw_i) == '0);

  p_no_spurious_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_i & ~$past(raw_i) & ~$past(evt_i) & ~LEVEL) == '0));

  p_evt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & clr_i & ~LEVEL) |=> ((($past(evt_i) & ~LEVEL) & ~raw_i) == '0));

  p_abort_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[ABIT] && !evt_i[ABIT]) |=> abrt_i == '0);
endmodule

bind i2c_irq_ctrl i2c_irq_chk #(
  .NSRC (NSRC),
  .AW_C (AW_C),
  .ABIT (ABIT),
  .LEVEL(LEVEL)
) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .evt_i (evt_i),
  .clr_i (clr_vec),
  .raw_i (raw),
  .mask_i(mask_q),
  .abrt_i(abrt_q),
  .irq_i (irq_o)
);

// File: tb/i2c_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_ctrl_tb_top;
  localparam int ADR_RAW = 0, ADR_STAT = 1, ADR_MASK = 2, ADR_ABRT = 3;
  localparam int ADR_ALL = 4, ADR_CB = 8;
  localparam logic [1:0] K_WR = 2'd0, K_EV = 2'd1, K_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [5:0]  addr;
    logic [15:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'h000, 4'd1},  // R1
    '{K_RD, 6'(ADR_MASK),   16'h0000, 32'h000, 4'd1},  // R1
    '{K_EV, 6'd0,           16'h0A01, 32'h000, 4'd2},
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'hA01, 4'd2},  // R2
    '{K_WR, 6'(ADR_MASK),   16'h0201, 32'h000, 4'd3},
    '{K_RD, 6'(ADR_STAT),   16'h0000, 32'h201, 4'd3},  // R3
    '{K_RD, 6'(ADR_CB),     16'h0000, 32'h001, 4'd4},  // R4
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'hA00, 4'd4},  // R4
    '{K_WR, 6'(ADR_CB + 11),16'h0FFF, 32'h000, 4'd10},
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'hA00, 4'd10}, // R10
    '{K_RD, 6'(ADR_CB + 9), 16'h0000, 32'h001, 4'd4},  // R4
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'h800, 4'd4},
    '{K_WR, 6'(ADR_RAW),    16'h0FFF, 32'h000, 4'd9},
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'h800, 4'd9},  // R9
    '{K_RD, 6'(ADR_ALL),    16'h0000, 32'h000, 4'd5},  // R5
    '{K_RD, 6'(ADR_RAW),    16'h0000, 32'h000, 4'd5},  // R5
    '{K_RD, 6'(ADR_CB + 3), 16'h0000, 32'h000, 4'd4}   // R4
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic [12:0] abrt_cause_i = '0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic [11:0] lvl = '0;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  i2c_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .abrt_cause_i(abrt_cause_i),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_read(input int a, input logic [31:0] exp, input string rq);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = 6'(a);
    #1 chk(rq, reg_rdata_o, exp);
    @(negedge clk_i);
    reg_req_i = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 6'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk_i);
    evt_i = e | lvl;
    @(negedge clk_i);
    evt_i = lvl;
  endtask

  // clear read and event raised in the same cycle
  task automatic clr_and_evt(input int a, input logic [11:0] e);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = 6'(a);
    evt_i = e | lvl;
    @(negedge clk_i);
    reg_req_i = 1'b0; evt_i = lvl;
  endtask

  task automatic set_lvl(input logic [11:0] v);
    @(negedge clk_i);
    lvl = v; evt_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    do_read(ADR_ABRT, 32'h0, "R1 abort");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR: do_write(int'(VEC[i].addr), {16'h0, VEC[i].data});
        K_EV: pulse(VEC[i].data[11:0]);
        default: do_read(int'(VEC[i].addr), VEC[i].exp,
                         $sformatf("R%0d vec %0d", VEC[i].req, i));
      endcase
    end

    // R3: interrupt line follows masked bits only (mask is 0x201)
    pulse(12'h002);
    chk("R3 masked-off source", {31'b0, irq_o}, 32'h0);
    pulse(12'h200);
    chk("R3 enabled source", {31'b0, irq_o}, 32'h1);
    do_read(ADR_CB + 9, 32'h1, "R4 clr stop");
    chk("R3 irq after clear", {31'b0, irq_o}, 32'h0);
    do_read(ADR_ALL, 32'h0, "R5 clr all");

    // R6: level sources
    set_lvl(12'h004);
    do_read(ADR_RAW, 32'h004, "R6 level set");
    do_read(ADR_CB + 2, 32'h1, "R6 clr read");
    do_read(ADR_RAW, 32'h004, "R6 after own clear");
    do_read(ADR_ALL, 32'h0, "R6 clr all");
    set_lvl(12'h010);
    do_read(ADR_RAW, 32'h010, "R6 level follows");
    set_lvl(12'h000);
    do_read(ADR_RAW, 32'h000, "R6 level low");

    // R7: event and clear in the same cycle
    clr_and_evt(ADR_CB + 5, 12'h020);
    do_read(ADR_RAW, 32'h020, "R7 per-source race");
    clr_and_evt(ADR_ALL, 12'h001);
    do_read(ADR_RAW, 32'h001, "R7 clear-all race");
    do_read(ADR_ALL, 32'h0, "R5 clr all");

    // R8: abort-cause register
    abrt_cause_i = 13'h1FFF;
    pulse(12'h040);
    do_read(ADR_ABRT, 32'h1EBF, "R8 defined bits");
    do_read(ADR_RAW, 32'h040, "R8 abort status");
    do_read(ADR_CB + 6, 32'h1, "R8 clr abort");
    do_read(ADR_ABRT, 32'h0, "R8 cleared");
    do_read(ADR_RAW, 32'h0, "R8 status cleared");
    pulse(12'h000);
    do_read(ADR_ABRT, 32'h0, "R8 cause without event");
    abrt_cause_i = 13'h0001;
    pulse(12'h040);
    abrt_cause_i = 13'h1000;
    pulse(12'h040);
    do_read(ADR_ABRT, 32'h1001, "R8 accumulate");
    do_read(ADR_ALL, 32'h0, "R5 clr all");
    do_read(ADR_ABRT, 32'h0, "R5 abort cleared by clear-all");
    abrt_cause_i = 13'h0008;
    pulse(12'h040);
    abrt_cause_i = 13'h0010;
    clr_and_evt(ADR_CB + 6, 12'h040);
    do_read(ADR_ABRT, 32'h0010, "R7 abort race keeps new cause");
    do_read(ADR_RAW, 32'h040, "R7 abort bit kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule